// File: doc/BRIEF.md
# Per-Net Transition Activity Scorer

This block watches a group of monitored nets while a sequence of test vectors is applied. Each vector is held for a window of one or more clock cycles. Inside a window, the block counts how often each net changes value. When a vector-boundary strobe closes the window, the count for each net is compared with a programmable threshold. The block then bumps one of two counters kept for that net. One counter tracks windows judged suspicious, where the count was strictly above the threshold. The other tracks windows judged ordinary.

The ratio of suspicious to ordinary windows forms an activity weight for each net. A higher weight marks a net that more likely carries hidden logic. Such a net switches far more often than its neighbours under stimuli that should leave it quiet. The block exposes both counters for every net. It also reports the index of the net with the highest weight, so a test controller can rank candidates without doing any division. Primary inputs may sit unchanged for several cycles while state elements keep switching, so windows of any length are supported.

Top module: `toggle_weight_ranker`

## Requirements
- R1: After reset, every suspicious and ordinary counter reads 0 and the top-net index reads 0.
- R2: A transition is a change of a net between the values sampled on two consecutive clock cycles. The cycle that carries the strobe also counts towards the window it closes. After reset, the previously sampled value of every net is taken as 0.
- R3: When the strobe is sampled, a net whose window count is strictly greater than the threshold has its suspicious counter incremented. Any other net, including one whose count equals the threshold, has its ordinary counter incremented. The new values are visible on the outputs from the cycle after the strobe.
- R4: The first cycle after a strobe is compared with the last cycle of the previous window, so a change across the boundary counts in the new window.
- R5: Windows may be any number of cycles long. The per-window count saturates at 255.
- R6: The suspicious and ordinary counters saturate at 65535.
- R7: A clear zeroes every counter and every open window count on the next cycle. A strobe in the same cycle as a clear has no effect.
- R8: The top-net index names the net with the largest ratio of suspicious to ordinary count. A net whose ordinary count is 0 holds the maximum weight.
- R9: When several nets share the largest weight, the lowest index is reported.
- R10: Without a strobe or clear, no suspicious or ordinary counter changes, whatever the nets do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| net_in | input | 8 | Monitored nets, sampled every cycle |
| vec_end | input | 1 | Closes the current vector window in this cycle |
| thresh | input | 8 | Transition count that a window must exceed to be judged suspicious |
| clear | input | 1 | Zeroes all counters |
| hi_cnt | output | 128 | Suspicious-window counters; net n at bits [16n+15:16n] |
| lo_cnt | output | 128 | Ordinary-window counters; net n at bits [16n+15:16n] |
| top_idx | output | 3 | Index of the net with the highest weight |

## Verification
The scorer is first driven with short windows in which some nets toggle every cycle and others toggle exactly as often as the threshold. This separates a strict comparison from an inclusive one. Further patterns place a net's change right on the strobe cycle and right after it, which shows whether boundary transitions are kept or dropped. A 300-cycle toggling window at thresholds 254 and 255 checks the window count saturation. Ranking patterns build equal ratios, ratios that differ only after cross-multiplication, and nets with no ordinary windows; these tell apart the tie rule, the ratio order and the zero-divisor rule. A run of 65540 windows checks the counter ceiling.

// File: rtl/tw_pkg.sv
// Shared types for the transition activity scorer.
// Assumes nothing beyond a single clock domain.
package tw_pkg;
    // Verdict a lane reaches for its net in a given cycle
    typedef enum logic [1:0] {
        VERDICT_NONE = 2'd0,
        VERDICT_LOW  = 2'd1,
        VERDICT_HIGH = 2'd2
    } verdict_e;
endpackage

// File: rtl/tw_toggle_detect.sv
// Keeps the previously sampled value of every monitored net and flags
// which nets changed since the last cycle. Assumes all nets are already
// synchronous to clk; the stored value resets to all zeros.
module tw_toggle_detect #(
    parameter int NETS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NETS-1:0] net_in,
    output logic [NETS-1:0] toggles
);
    logic [NETS-1:0] prev_q;

    // Remember the value seen this cycle for the next comparison
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= net_in;
    end

    // A net toggled if it differs from the previous sample
    always_comb toggles = net_in ^ prev_q;
endmodule

// File: rtl/tw_lane.sv
// One lane per monitored net. It counts transitions over the open window
// and, when the window closes, judges it against the threshold and bumps
// either the suspicious or the ordinary saturating counter.
// Assumes the toggle input already includes the strobe cycle's change.
module tw_lane
    import tw_pkg::*;
#(
    parameter int WIN_W = 8,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             toggle,
    input  logic             close,
    input  logic             clear,
    input  logic [WIN_W-1:0] thresh,
    output logic [CNT_W-1:0] hi_cnt,
    output logic [CNT_W-1:0] lo_cnt
);
    localparam logic [WIN_W-1:0] WIN_MAX = {WIN_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [WIN_W-1:0] win_q;
    logic [WIN_W-1:0] win_next;
    verdict_e         verdict;

    // Window count including this cycle's change, held at its ceiling
    always_comb begin
        if (win_q == WIN_MAX) win_next = WIN_MAX;
        else                  win_next = win_q + WIN_W'(toggle);
    end

    // Judge the window only in the cycle that closes it
    always_comb begin
        if (!close)                verdict = VERDICT_NONE;
        else if (win_next > thresh) verdict = VERDICT_HIGH;
        else                       verdict = VERDICT_LOW;
    end

    // Window counter: restarts on close, cleared by clear
    always_ff @(posedge clk) begin
        if (!rst_n || clear) win_q <= '0;
        else if (close)      win_q <= '0;
        else                 win_q <= win_next;
    end

    // Suspicious-window counter, saturating
    always_ff @(posedge clk) begin
        if (!rst_n || clear) hi_cnt <= '0;
        else if (verdict == VERDICT_HIGH && hi_cnt != CNT_MAX)
            hi_cnt <= hi_cnt + 1'b1;
    end

    // Ordinary-window counter, saturating
    always_ff @(posedge clk) begin
        if (!rst_n || clear) lo_cnt <= '0;
        else if (verdict == VERDICT_LOW && lo_cnt != CNT_MAX)
            lo_cnt <= lo_cnt + 1'b1;
    end
endmodule

// File: rtl/tw_ranker.sv
// Finds the net with the largest suspicious/ordinary ratio without
// division. Ratios are compared by cross-multiplication; a zero ordinary
// count is the largest weight; only a strictly larger weight displaces
// the current best, so ties keep the lowest index. Purely combinational.
module tw_ranker #(
    parameter int NETS  = 8,
    parameter int CNT_W = 16,
    parameter int IDX_W = 3
) (
    input  logic [NETS*CNT_W-1:0] hi_flat,
    input  logic [NETS*CNT_W-1:0] lo_flat,
    output logic [IDX_W-1:0]      top_idx
);
    localparam int PROD_W = 2 * CNT_W;

    // Linear scan keeping the best candidate seen so far
    always_comb begin
        logic [IDX_W-1:0]  best;
        logic [CNT_W-1:0]  best_hi, best_lo, cand_hi, cand_lo;
        logic [PROD_W-1:0] lhs, rhs;
        logic              wins;
        best    = '0;
        best_hi = hi_flat[0 +: CNT_W];
        best_lo = lo_flat[0 +: CNT_W];
        for (int i = 1; i < NETS; i++) begin
            cand_hi = hi_flat[i*CNT_W +: CNT_W];
            cand_lo = lo_flat[i*CNT_W +: CNT_W];
            lhs = PROD_W'(cand_hi) * PROD_W'(best_lo);
            rhs = PROD_W'(best_hi) * PROD_W'(cand_lo);
            if (cand_lo == '0)      wins = (best_lo != '0);
            else if (best_lo == '0) wins = 1'b0;
            else                    wins = (lhs > rhs);
            if (wins) begin
                best    = IDX_W'(i);
                best_hi = cand_hi;
                best_lo = cand_lo;
            end
        end
        top_idx = best;
    end
endmodule

// File: rtl/toggle_weight_ranker.sv
// Top of the transition activity scorer. Samples the monitored nets,
// runs one judging lane per net and ranks the nets by activity weight.
// Assumes at least two nets; counters appear on the cycle after a strobe.
module toggle_weight_ranker #(
    parameter int NETS  = 8,
    parameter int WIN_W = 8,
    parameter int CNT_W = 16,
    localparam int IDX_W = (NETS > 1) ? $clog2(NETS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NETS-1:0]       net_in,
    input  logic                  vec_end,
    input  logic [WIN_W-1:0]      thresh,
    input  logic                  clear,
    output logic [NETS*CNT_W-1:0] hi_cnt,
    output logic [NETS*CNT_W-1:0] lo_cnt,
    output logic [IDX_W-1:0]      top_idx
);
    logic [NETS-1:0] toggles;

    tw_toggle_detect #(.NETS(NETS)) u_detect (
        .clk     (clk),
        .rst_n   (rst_n),
        .net_in  (net_in),
        .toggles (toggles)
    );

    // One judging lane for every monitored net
    for (genvar n = 0; n < NETS; n++) begin : g_lane
        tw_lane #(.WIN_W(WIN_W), .CNT_W(CNT_W)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .toggle (toggles[n]),
            .close  (vec_end),
            .clear  (clear),
            .thresh (thresh),
            .hi_cnt (hi_cnt[n*CNT_W +: CNT_W]),
            .lo_cnt (lo_cnt[n*CNT_W +: CNT_W])
        );
    end

    tw_ranker #(.NETS(NETS), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_rank (
        .hi_flat (hi_cnt),
        .lo_flat (lo_cnt),
        .top_idx (top_idx)
    );
endmodule

// File: rtl/tw_checker.sv
// Assertions for the transition activity scorer, bound to its top.
module tw_checker #(
    parameter int NETS  = 8,
    parameter int CNT_W = 16,
    parameter int IDX_W = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  vec_end,
    input logic                  clear,
    input logic [NETS*CNT_W-1:0] hi_cnt,
    input logic [NETS*CNT_W-1:0] lo_cnt,
    input logic [IDX_W-1:0]      top_idx
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [NETS-1:0] lo_zero;

    // Which nets currently hold the maximum weight
    always_comb
        for (int i = 0; i < NETS; i++)
            lo_zero[i] = (lo_cnt[i*CNT_W +: CNT_W] == '0);

    assert_clear_zeroes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (hi_cnt == '0 && lo_cnt == '0));

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!vec_end && !clear) |=> ($stable(hi_cnt) && $stable(lo_cnt)));

    assert_max_weight_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|lo_zero) |-> lo_zero[top_idx]);

    for (genvar n = 0; n < NETS; n++) begin : g_net
        logic [CNT_W-1:0] hi_n, lo_n;
        logic [CNT_W:0]   sum_n;
        always_comb begin
            hi_n  = hi_cnt[n*CNT_W +: CNT_W];
            lo_n  = lo_cnt[n*CNT_W +: CNT_W];
            sum_n = {1'b0, hi_n} + {1'b0, lo_n};
        end

        assert_one_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (vec_end && !clear && hi_n != CNT_MAX && lo_n != CNT_MAX)
            |=> (sum_n == $past(sum_n) + 1'b1));

        assert_hi_sat_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (hi_n == CNT_MAX && !clear) |=> (hi_n == CNT_MAX));

        assert_lo_sat_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (lo_n == CNT_MAX && !clear) |=> (lo_n == CNT_MAX));
    end
endmodule

bind toggle_weight_ranker tw_checker #(
    .NETS(NETS), .CNT_W(CNT_W), .IDX_W(IDX_W)
) u_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .vec_end (vec_end),
    .clear   (clear),
    .hi_cnt  (hi_cnt),
    .lo_cnt  (lo_cnt),
    .top_idx (top_idx)
);

// File: tb/toggle_weight_ranker_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module toggle_weight_ranker_tb;
    localparam int NETS = 8;
    localparam int CW   = 16;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [NETS-1:0] net_in;
    logic            vec_end;
    logic [7:0]      thresh;
    logic            clear;
    logic [NETS*CW-1:0] hi_cnt, lo_cnt;
    logic [2:0]      top_idx;

    int n_chk  = 0;
    int n_fail = 0;

    // Expected state derived from the requirements
    logic [NETS-1:0] m_prev;
    int m_win [NETS];
    int m_hi  [NETS];
    int m_lo  [NETS];

    always #5 clk = ~clk;

    toggle_weight_ranker u_dut (
        .clk(clk), .rst_n(rst_n), .net_in(net_in), .vec_end(vec_end),
        .thresh(thresh), .clear(clear), .hi_cnt(hi_cnt), .lo_cnt(lo_cnt),
        .top_idx(top_idx)
    );

    function automatic int hi_of(int i); return int'(hi_cnt[i*CW +: CW]); endfunction
    function automatic int lo_of(int i); return int'(lo_cnt[i*CW +: CW]); endfunction

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Net with the largest hi/lo ratio; zero lo is infinite; ties keep lowest
    function automatic int model_top();
        int best = 0;
        for (int i = 1; i < NETS; i++) begin
            longint a = longint'(m_hi[i]) * m_lo[best];
            longint b = longint'(m_hi[best]) * m_lo[i];
            if (m_lo[best] == 0) continue;
            if (m_lo[i] == 0 || a > b) best = i;
        end
        return best;
    endfunction

    // Drive one cycle at the falling edge, then advance the expected state
    task automatic cyc(logic [NETS-1:0] n, logic e, logic c);
        net_in = n; vec_end = e; clear = c;
        @(negedge clk);
        for (int i = 0; i < NETS; i++) begin
            int tg = (n[i] != m_prev[i]) ? 1 : 0;
            if (c) begin
                m_win[i] = 0; m_hi[i] = 0; m_lo[i] = 0;
            end else if (e) begin
                int tot = m_win[i] + tg;
                if (tot > 255) tot = 255;
                if (tot > int'(thresh)) begin
                    if (m_hi[i] < 65535) m_hi[i]++;
                end else begin
                    if (m_lo[i] < 65535) m_lo[i]++;
                end
                m_win[i] = 0;
            end else begin
                m_win[i] = (m_win[i] + tg > 255) ? 255 : m_win[i] + tg;
            end
        end
        m_prev = n;
    endtask

    task automatic compare_all(string req);
        for (int i = 0; i < NETS; i++) begin
            check(req, $sformatf("hi[%0d]", i), hi_of(i), m_hi[i]);
            check(req, $sformatf("lo[%0d]", i), lo_of(i), m_lo[i]);
        end
        check(req, "top_idx", int'(top_idx), model_top());
    endtask

    task automatic do_clear();
        cyc(net_in, 1'b0, 1'b1);
    endtask

    task automatic t_reset();
        for (int i = 0; i < NETS; i++) begin
            check("R1", "hi after reset", hi_of(i), 0);
            check("R1", "lo after reset", lo_of(i), 0);
        end
        check("R1", "top after reset", int'(top_idx), 0);
    endtask

    // R2/R3: strict compare, strobe cycle counted, initial previous value 0
    task automatic t_threshold();
        thresh = 8'd2;
        cyc(8'h03, 1'b0, 1'b0);
        cyc(8'h02, 1'b0, 1'b0);
        cyc(8'h01, 1'b0, 1'b0);
        cyc(8'h00, 1'b1, 1'b0);
        check("R3", "net0 four toggles above 2", hi_of(0), 1);
        check("R3", "net1 two toggles equal to 2", lo_of(1), 1);
        check("R2", "net1 not suspicious", hi_of(1), 0);
        check("R8", "net0 zero lo wins", int'(top_idx), 0);
        compare_all("R2");
    endtask

    // R4: changes on and just after the strobe stay in their windows
    task automatic t_boundary();
        do_clear();
        thresh = 8'd0;
        cyc(8'h00, 1'b1, 1'b0);
        cyc(8'h04, 1'b0, 1'b0);
        cyc(8'h04, 1'b1, 1'b0);
        check("R4", "net2 change after boundary", hi_of(2), 1);
        check("R4", "net2 quiet window", lo_of(2), 1);
        cyc(8'h04, 1'b0, 1'b0);
        cyc(8'h00, 1'b1, 1'b0);
        check("R2", "net2 change on strobe cycle", hi_of(2), 2);
        compare_all("R4");
    endtask

    // R10: busy nets without strobe leave counters alone
    task automatic t_hold();
        int snap_hi = hi_of(2);
        int snap_lo = lo_of(0);
        for (int k = 0; k < 20; k++) cyc((k % 2) ? 8'hFF : 8'h00, 1'b0, 1'b0);
        check("R10", "hi net2 unchanged", hi_of(2), snap_hi);
        check("R10", "lo net0 unchanged", lo_of(0), snap_lo);
        compare_all("R10");
    endtask

    // R7: clear wins over strobe and discards the open window
    task automatic t_clear();
        thresh = 8'd0;
        cyc(8'hFF, 1'b1, 1'b1);
        for (int i = 0; i < NETS; i++) begin
            check("R7", "hi zero after clear", hi_of(i), 0);
            check("R7", "lo zero after clear", lo_of(i), 0);
        end
        cyc(8'hFF, 1'b1, 1'b0);
        check("R7", "open window discarded", lo_of(5), 1);
        compare_all("R7");
    endtask

    // R5: long window saturates its count at 255
    task automatic t_window_sat();
        do_clear();
        thresh = 8'd254;
        for (int k = 0; k < 300; k++) cyc((k % 2) ? 8'h08 : 8'h00, k == 299, 1'b0);
        check("R5", "300 toggles above 254", hi_of(3), 1);
        thresh = 8'd255;
        for (int k = 0; k < 300; k++) cyc((k % 2) ? 8'h00 : 8'h08, k == 299, 1'b0);
        check("R5", "count capped at 255 not above 255", lo_of(3), 1);
        compare_all("R5");
    endtask

    // One window in which the nets of mask toggle once
    task automatic rank_window(logic [NETS-1:0] mask);
        cyc(net_in ^ mask, 1'b0, 1'b0);
        cyc(net_in, 1'b1, 1'b0);
    endtask

    // R8/R9: ratio order, equal ratios, zero ordinary counts
    task automatic t_rank();
        do_clear();
        thresh = 8'd0;
        rank_window(8'hE0);
        rank_window(8'h60);
        rank_window(8'h00);
        check("R9", "nets 5,6 tie at 2/1", int'(top_idx), 5);
        compare_all("R9");
        rank_window(8'h40);
        check("R8", "net6 3/1 beats net5 2/2", int'(top_idx), 6);
        compare_all("R8");
        do_clear();
        rank_window(8'h48);
        check("R9", "two zero-lo nets, lowest wins", int'(top_idx), 3);
        compare_all("R8");
    endtask

    // R6: ordinary counters stop at 65535
    task automatic t_counter_sat();
        do_clear();
        thresh = 8'd255;
        for (int k = 0; k < 65540; k++) cyc(8'h00, 1'b1, 1'b0);
        for (int i = 0; i < NETS; i++)
            check("R6", "lo saturated", lo_of(i), 65535);
        check("R6", "hi stays zero", hi_of(0), 0);
        compare_all("R6");
    endtask

    initial begin
        for (int i = 0; i < NETS; i++) begin m_win[i] = 0; m_hi[i] = 0; m_lo[i] = 0; end
        m_prev = '0;
        rst_n = 1'b0; net_in = '0; vec_end = 1'b0; clear = 1'b0; thresh = 8'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_threshold();
        t_boundary();
        t_hold();
        t_clear();
        t_window_sat();
        t_rank();
        t_counter_sat();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule